// File: doc/BRIEF.md
# I2C Slave with Clock-Stretch Handshake

This block is a byte-level two-wire bus slave. The slave holds the clock line low after every acknowledge slot in which it took part. The line stays low until the local CPU has dealt with the byte and issued a release strobe. The CPU therefore sets the pace of every transfer: it reads each received byte, or supplies the next byte to send, while the host is stalled.

The block watches the synchronized SCL and SDA levels. It drives both lines only as open-drain pull-low requests. The CPU side gives the block a 7-bit own address, a transmit byte, a direction bit for the next byte and an acknowledge-disable bit. The block returns the last received byte, the first-byte, read/write and address-match flags, a stop flag, the host's acknowledge bit and one interrupt. For every transfer the CPU chooses whether the next byte is received or sent.

Top module: `i2c_stretch_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After reset, interrupt, stop flag and both pull-low outputs are 0.
- R2: The first byte after a start is taken MSB first, with bits 7..1 as the address and bit 0 as direction. If bits 7..1 equal the own address, the slave pulls SDA low in the ninth slot when the acknowledge-disable bit is 0. On a mismatch it never drives SDA, raises no interrupt and does not stretch.
- R3: When the slave's acknowledge slot ends (SCL falls), the interrupt rises and SCL is held low until a release strobe. The release frees SCL and clears the interrupt on the next clock.
- R4: After a matched address, the received-byte output holds the address byte, first-byte is 1, read/write equals bit 0 (1 = read) and address-match is 1.
- R5: If the direction bit is 0 at release, the next byte is received MSB first into the received-byte output with first-byte 0. It is acknowledged by SDA low unless acknowledge-disable is 1, in which case SDA stays high. The interrupt follows the slot.
- R6: If the direction bit is 1 at release, the transmit byte is sent MSB first, one bit per SCL low phase. The host's ninth bit is stored in the received-acknowledge flag (0 = ACK, 1 = NACK). A host ACK raises the interrupt and stretches SCL.
- R7: After a host NACK the slave goes idle, raises no interrupt, does not stretch and leaves SDA undriven until the next start.
- R8: A stop while the slave is addressed sets the stop flag and the interrupt, and a release clears both. A stop while the slave is not addressed leaves the stop flag at 0.
- R9: The SDA pull-low output changes only in cycles where SCL was low. A start in the middle of a byte discards the partial byte and begins address reception again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| own_addr | input | ADDR_W | Slave address |
| tx_byte | input | ADDR_W+1 | Byte to send in a read transfer |
| tx_dir | input | 1 | Direction of next byte at release: 1 send, 0 receive |
| ack_dis | input | 1 | 1 answers received bytes with NACK |
| release_i | input | 1 | One-cycle strobe: free SCL, clear interrupt and stop flag |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |
| rx_byte | output | ADDR_W+1 | Last received byte |
| first_o | output | 1 | Received byte was the address byte |
| rw_o | output | 1 | Direction bit of the address byte |
| match_o | output | 1 | Last address matched |
| stop_o | output | 1 | Stop seen while addressed |
| rx_ack_o | output | 1 | Host acknowledge bit after a sent byte |
| irq_o | output | 1 | Interrupt |

## Verification
The bench builds the block with the default ADDR_W of 7, so bytes are 8 bits wide and the address comparison covers the full 7-bit field. The own address is drawn at random once, and random addresses that do and do not match it are mixed into the sequence. This exercises the match, no-match, write, read and NACK paths against one configuration. The bench models the host with open-drain wired-AND lines, so the stretch stalls the host and the host's SDA level is combined with the slave's pull-low output. This makes the ACK bits, the transmitted bits and a mid-byte repeated start observable on the bus itself.

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W:0]   tx_byte,
  input  logic              tx_dir,
  input  logic              ack_dis,
  input  logic              release_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic [ADDR_W:0]   rx_byte,
  output logic              first_o,
  output logic              rw_o,
  output logic              match_o,
  output logic              stop_o,
  output logic              rx_ack_o,
  output logic              irq_o
);
  localparam int BW = ADDR_W + 1;
  localparam int CW = $clog2(BW + 1);

  typedef enum logic [2:0] {IDLE, RECV, AACK, SEND, MACK, HOLD} st_t;

  st_t           st;
  logic          scl_q, sda_q, sel, addr_ph;
  logic [CW-1:0] cnt;
  logic [BW-1:0] sh;

  wire scl_rise  = scl_i & ~scl_q;
  wire scl_fall  = ~scl_i & scl_q;
  wire start_ev  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_ev   = scl_i & scl_q & ~sda_q & sda_i;
  wire byte_done = (cnt == CW'(BW));
  wire last_bit  = (cnt == CW'(BW - 1));
  wire hit       = (sh[BW-1:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      sel       <= 1'b0;
      addr_ph   <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      rx_byte   <= '0;
      first_o   <= 1'b0;
      rw_o      <= 1'b0;
      match_o   <= 1'b0;
      stop_o    <= 1'b0;
      rx_ack_o  <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (release_i) begin
        irq_o  <= 1'b0;
        stop_o <= 1'b0;
      end
      if (stop_ev) begin
        st        <= IDLE;
        cnt       <= '0;
        sda_low_o <= 1'b0;
        scl_low_o <= 1'b0;
        sel       <= 1'b0;
        if (sel) begin
          stop_o <= 1'b1;
          irq_o  <= 1'b1;
        end
      end else if (start_ev) begin
        st        <= RECV;
        addr_ph   <= 1'b1;
        cnt       <= '0;
        sda_low_o <= 1'b0;
        stop_o    <= 1'b0;
        sel       <= 1'b0;
      end else begin
        case (st)
          RECV: begin
            if (scl_rise && !byte_done) begin
              sh  <= {sh[BW-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && byte_done) begin
              cnt <= '0;
              if (addr_ph && !hit) begin
                match_o <= 1'b0;
                st      <= IDLE;
              end else begin
                if (addr_ph) begin
                  sel     <= 1'b1;
                  match_o <= 1'b1;
                  rw_o    <= sh[0];
                end
                addr_ph   <= 1'b0;
                first_o   <= addr_ph;
                rx_byte   <= sh;
                sda_low_o <= ~ack_dis;
                st        <= AACK;
              end
            end
          end
          AACK: begin
            if (scl_fall) begin
              sda_low_o <= 1'b0;
              scl_low_o <= 1'b1;
              irq_o     <= 1'b1;
              st        <= HOLD;
            end
          end
          HOLD: begin
            if (release_i) begin
              scl_low_o <= 1'b0;
              cnt       <= '0;
              if (tx_dir) begin
                sh        <= tx_byte;
                sda_low_o <= ~tx_byte[BW-1];
                st        <= SEND;
              end else begin
                st <= RECV;
              end
            end
          end
          SEND: begin
            if (scl_fall) begin
              if (last_bit) begin
                sda_low_o <= 1'b0;
                cnt       <= '0;
                st        <= MACK;
              end else begin
                cnt       <= cnt + 1'b1;
                sh        <= {sh[BW-2:0], 1'b0};
                sda_low_o <= ~sh[BW-2];
              end
            end
          end
          MACK: begin
            if (scl_rise) begin
              rx_ack_o <= sda_i;
            end else if (scl_fall) begin
              if (rx_ack_o) begin
                st <= IDLE;
              end else begin
                scl_low_o <= 1'b1;
                irq_o     <= 1'b1;
                st        <= HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_stretch_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic release_i,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic stop_o,
  input logic irq_o
);
  p_hold_has_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low_o |-> irq_o);

  p_release_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && scl_low_o) |=> (!scl_low_o && !irq_o));

  p_no_dual_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_low_o && scl_low_o));

  p_sda_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_o) |-> !$past(scl_i));

  p_stop_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> irq_o);
endmodule

bind i2c_stretch_slave i2c_stretch_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .release_i(release_i),
  .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .stop_o(stop_o), .irq_o(irq_o)
);

// File: tb/test_i2c_stretch_slave.sv
`timescale 1ns/1ps
module test_i2c_stretch_slave;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic [AW-1:0] own_addr = '0;
  logic [AW:0] tx_byte = '0;
  logic tx_dir = 1'b0, ack_dis = 1'b0, release_i = 1'b0;
  logic scl_low_o, sda_low_o, first_o, rw_o, match_o, stop_o, rx_ack_o, irq_o;
  logic [AW:0] rx_byte;
  int checks = 0, errors = 0;

  wire scl_line = host_scl & ~scl_low_o;
  wire sda_line = host_sda & ~sda_low_o;

  always #5 clk = ~clk;

  i2c_stretch_slave #(.ADDR_W(AW)) i_i2c_stretch_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .own_addr(own_addr), .tx_byte(tx_byte), .tx_dir(tx_dir), .ack_dis(ack_dis),
    .release_i(release_i), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .rx_byte(rx_byte), .first_o(first_o), .rw_o(rw_o), .match_o(match_o),
    .stop_o(stop_o), .rx_ack_o(rx_ack_o), .irq_o(irq_o));

  function automatic logic exp_ack(input logic [AW:0] first_byte, input logic [AW-1:0] me);
    return (first_byte[AW:1] == me) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    for (int n = 0; n < 4000 && !scl_line; n++) @(negedge clk);
  endtask

  task automatic h_start();
    host_sda = 1'b1; tick(4);
    host_scl = 1'b1; wait_high(); tick(4);
    host_sda = 1'b0; tick(4);
    host_scl = 1'b0; tick(4);
  endtask

  task automatic h_stop();
    host_sda = 1'b0; tick(4);
    host_scl = 1'b1; wait_high(); tick(4);
    host_sda = 1'b1; tick(4);
  endtask

  task automatic h_bit(input logic b, output logic r);
    host_sda = b; tick(4);
    host_scl = 1'b1; wait_high(); tick(3);
    r = sda_line; tick(3);
    host_scl = 1'b0; tick(4);
  endtask

  task automatic h_wr(input logic [AW:0] d, output logic ack);
    logic r;
    for (int i = AW; i >= 0; i--) h_bit(d[i], r);
    h_bit(1'b1, ack);
  endtask

  task automatic h_rd(input logic ack, output logic [AW:0] d);
    logic r;
    for (int i = AW; i >= 0; i--) begin
      h_bit(1'b1, r);
      d[i] = r;
    end
    h_bit(ack, r);
  endtask

  task automatic cpu_release(input logic dir, input logic [AW:0] t);
    tx_dir = dir; tx_byte = t; release_i = 1'b1; tick(1);
    release_i = 1'b0; tick(2);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic [AW:0] d, dn, a;
    logic r;
    void'($urandom(32'd1234));
    own_addr = AW'($urandom);
    tick(5); rst_n = 1'b1; tick(3);
    chk("R1", "reset irq", irq_o, 0);
    chk("R1", "reset scl pull", scl_low_o, 0);
    chk("R1", "reset sda pull", sda_low_o, 0);
    chk("R1", "reset stop", stop_o, 0);

    // write transfer with matched address
    h_start();
    h_wr({own_addr, 1'b0}, ack);
    chk("R2", "address ack", ack, 0);
    chk("R3", "irq after ack", irq_o, 1);
    chk("R3", "scl held", scl_low_o, 1);
    chk("R4", "address byte", rx_byte, {own_addr, 1'b0});
    chk("R4", "first flag", first_o, 1);
    chk("R4", "rw flag", rw_o, 0);
    chk("R4", "match flag", match_o, 1);
    tick(30);
    chk("R3", "scl line still low", scl_line, 0);
    cpu_release(1'b0, '0);
    chk("R3", "irq cleared", irq_o, 0);
    chk("R3", "scl freed", scl_low_o, 0);
    for (int k = 0; k < 4; k++) begin
      d = (AW+1)'($urandom);
      h_wr(d, ack);
      chk("R5", "data ack", ack, 0);
      chk("R5", "data irq", irq_o, 1);
      chk("R5", "data byte", rx_byte, d);
      chk("R5", "first cleared", first_o, 0);
      cpu_release(1'b0, '0);
    end
    ack_dis = 1'b1;
    d = (AW+1)'($urandom);
    h_wr(d, ack);
    chk("R5", "nack when disabled", ack, 1);
    chk("R5", "irq with nack", irq_o, 1);
    cpu_release(1'b0, '0);
    ack_dis = 1'b0;
    h_stop(); tick(3);
    chk("R8", "stop flag", stop_o, 1);
    chk("R8", "stop irq", irq_o, 1);
    cpu_release(1'b0, '0);
    chk("R8", "stop flag cleared", stop_o, 0);
    chk("R8", "stop irq cleared", irq_o, 0);

    // mismatched address
    h_start();
    h_wr({own_addr ^ AW'(1), 1'b0}, ack);
    chk("R2", "mismatch nack", ack, 1);
    chk("R2", "mismatch no irq", irq_o, 0);
    chk("R2", "mismatch no stretch", scl_low_o, 0);
    h_stop(); tick(3);
    chk("R8", "no stop flag unaddressed", stop_o, 0);

    // read transfer
    h_start();
    h_wr({own_addr, 1'b1}, ack);
    chk("R2", "read address ack", ack, 0);
    chk("R4", "rw read", rw_o, 1);
    dn = (AW+1)'($urandom);
    cpu_release(1'b1, dn);
    for (int k = 0; k < 3; k++) begin
      d = dn;
      h_rd((k == 2) ? 1'b1 : 1'b0, a);
      chk("R6", "sent byte", a, d);
      if (k < 2) begin
        chk("R6", "host ack flag", rx_ack_o, 0);
        chk("R6", "irq after host ack", irq_o, 1);
        dn = (AW+1)'($urandom);
        cpu_release(1'b1, dn);
      end else begin
        chk("R6", "host nack flag", rx_ack_o, 1);
        chk("R7", "no irq after nack", irq_o, 0);
        chk("R7", "no stretch after nack", scl_low_o, 0);
      end
    end
    h_rd(1'b1, a);
    chk("R7", "sda undriven after nack", a, {(AW+1){1'b1}});
    h_stop(); tick(3);
    cpu_release(1'b0, '0);

    // start in mid byte aborts
    h_start();
    h_bit(1'b1, r); h_bit(1'b0, r); h_bit(1'b1, r);
    h_start();
    h_wr({own_addr, 1'b0}, ack);
    chk("R9", "ack after aborted byte", ack, 0);
    chk("R9", "address after abort", rx_byte, {own_addr, 1'b0});
    cpu_release(1'b0, '0);
    h_stop(); tick(3);
    cpu_release(1'b0, '0);

    // random mix
    for (int k = 0; k < 8; k++) begin
      a = ($urandom & 1) ? {own_addr, 1'b0} : (AW+1)'($urandom & ~1);
      h_start();
      h_wr(a, ack);
      chk("R2", "random address ack", ack, exp_ack(a, own_addr));
      if (!ack) begin
        cpu_release(1'b0, '0);
        d = (AW+1)'($urandom);
        h_wr(d, ack);
        chk("R5", "random data", rx_byte, d);
        cpu_release(1'b0, '0);
      end
      h_stop(); tick(3);
      chk("R8", "random stop flag", stop_o, !exp_ack(a, own_addr));
      cpu_release(1'b0, '0);
    end

    summary();
    $finish;
  end
endmodule